// File: doc/BRIEF.md
# Manchester Line Decoder with Sync Detection

This block turns a Manchester-coded serial line into plain serial data and a bit strobe. The line comes in either as a single unipolar wire or as a bipolar pair in which one wire signals high and the other signals low. A fast sampling clock runs at 16 or 32 times the bit rate. The block measures how long the line stays at each level and sorts every span into short (half a bit), long (one bit), sync (one and a half bits) or sync-plus-half (two bits, when the second sync half runs into the first half of the first data bit). Any other length is invalid.

A word opens with a two-span sync pattern. A high-then-low sync marks a command word and a low-then-high sync marks a data word. The block records which kind it saw and raises a code-valid flag. It then decodes a fixed number of bits. For each bit it drives the value on the serial output and gives one pulse on the bit strobe. A coding violation drops the valid flag, and decoding stops until the next sync. An asynchronous active-low reset clears every output at once.

Top module: `manch_decoder`

## Requirements
- R1: While `rst_n` is low, `dclk`, `sdo`, `sync_cmd` and `code_ok` are all 0, and they go to 0 as soon as `rst_n` falls. After release, no `dclk` pulse occurs until a new sync pattern has been recognised.
- R2: With `uni_sel`=1 the line level is `uni_in`, and `pos_in`/`neg_in` have no effect. With `uni_sel`=0, `pos_in` alone asserted means high, `neg_in` alone asserted means low, and both or neither asserted holds the previous level. A one-cycle overlap of both wires therefore decodes without error.
- R3: A bit period is 16 clocks with `rate_hi`=0 and 32 clocks with `rate_hi`=1. A span is accepted when it is within 2 clocks (16x) or 6 clocks (32x) of 0.5, 1.0, 1.5 or 2.0 bit periods. A sync half that is off by one clock more is rejected, and no word is decoded.
- R4: A 1.5-period span followed by a 1.5- or 2.0-period span of the opposite level is a sync. `code_ok` then goes to 1, and `sync_cmd` is set to 1 when the first sync half was high and to 0 when it was low.
- R5: Bit value 1 is sent as high then low, and 0 as low then high. After a sync, exactly WORD_BITS bits (17 by default) are output in the order received. Each bit gives one `dclk` pulse one clock wide, and `sdo` holds the bit during the pulse and during the clock before it.
- R6: Inside a word, a span outside every accepted window, a one-period span that starts at a bit boundary (a missing mid-bit transition), or a line with no transition for longer than one bit period plus tolerance drops `code_ok` to 0. No further `dclk` pulse occurs until the next sync.
- R7: Once the last bit of a word has been output, further Manchester transitions without a new sync give no `dclk` pulse, and `code_ok` and `sync_cmd` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16x or 32x the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uni_sel | input | 1 | 1 selects the unipolar line, 0 the bipolar pair |
| rate_hi | input | 1 | 0: 16 clocks per bit, 1: 32 clocks per bit |
| uni_in | input | 1 | Unipolar Manchester line |
| pos_in | input | 1 | Bipolar wire asserted for a high level |
| neg_in | input | 1 | Bipolar wire asserted for a low level |
| dclk | output | 1 | One-clock pulse per decoded bit |
| sdo | output | 1 | Decoded serial data |
| sync_cmd | output | 1 | 1 when the current word began with a command sync |
| code_ok | output | 1 | 1 while the current word is validly coded |

## Verification
The assertions check on every cycle the properties that hold for any input: the four span windows never overlap, the level is held while both bipolar wires are asserted, the strobe is one clock wide with stable data, the valid flag rises only out of the sync-wait state and falls only out of the data state, and the bit count never passes the word length. Only the bench scenarios can show that real waveforms decode to the right bit values in both sync polarities and at both rates, that sync spans exactly at the tolerance edge are taken or refused, that each kind of coding violation clears the flag, and that the bipolar inputs are ignored in unipolar mode. The same holds for reset in the middle of a word, which must give no strobe until a fresh sync.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [2:0] {
    SPAN_BAD   = 3'd0,
    SPAN_SHORT = 3'd1,
    SPAN_LONG  = 3'd2,
    SPAN_SYNC  = 3'd3,
    SPAN_SYNC2 = 3'd4
  } span_e;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_SYNC2 = 2'd1,
    ST_DATA  = 2'd2
  } dec_st_e;
endpackage

// File: rtl/mdec_line_in.sv
module mdec_line_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uni_sel,
  input  logic uni_in,
  input  logic pos_in,
  input  logic neg_in,
  output logic lvl_o
);
  logic [SYNC_STAGES-1:0] uni_s, pos_s, neg_s;
  logic u_w, p_w, n_w;
  logic lvl_d, lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uni_s <= '0;
      pos_s <= '0;
      neg_s <= '0;
    end else begin
      uni_s <= {uni_s[SYNC_STAGES-2:0], uni_in};
      pos_s <= {pos_s[SYNC_STAGES-2:0], pos_in};
      neg_s <= {neg_s[SYNC_STAGES-2:0], neg_in};
    end
  end

  assign u_w = uni_s[SYNC_STAGES-1];
  assign p_w = pos_s[SYNC_STAGES-1];
  assign n_w = neg_s[SYNC_STAGES-1];

  always_comb begin
    lvl_d = lvl_q;
    if (uni_sel)           lvl_d = u_w;
    else if (p_w && !n_w)  lvl_d = 1'b1;
    else if (n_w && !p_w)  lvl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;

  // R2
  overlap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uni_sel && p_w && n_w) |=> $stable(lvl_q));
endmodule

// File: rtl/mdec_span.sv
module mdec_span import mdec_pkg::*; #(
  parameter int BP_LO  = 16,
  parameter int BP_HI  = 32,
  parameter int TOL_LO = 2,
  parameter int TOL_HI = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rate_hi,
  input  logic  lvl,
  output logic  ev_vld,
  output span_e ev_cls,
  output logic  ev_lvl,
  output logic  overdue
);
  localparam int CW   = $clog2(2 * BP_HI + TOL_HI + 2) + 1;
  localparam int NCLS = 4;

  logic [CW-1:0] cnt_q, cnt_d, half_n, tol_n;
  logic          prv_q, edge_w;
  logic [NCLS-1:0] hit;
  logic [CW:0]   nom_a [NCLS];
  span_e         cls_w;
  logic          ev_vld_q, ev_lvl_q;
  span_e         ev_cls_q;

  assign half_n = rate_hi ? CW'(BP_HI / 2) : CW'(BP_LO / 2);
  assign tol_n  = rate_hi ? CW'(TOL_HI)    : CW'(TOL_LO);

  for (genvar k = 0; k < NCLS; k++) begin : g_win
    assign nom_a[k] = {1'b0, half_n} * (CW+1)'(k + 1);
    assign hit[k]   = ({1'b0, cnt_q} + {1'b0, tol_n} >= nom_a[k]) &&
                      ({1'b0, cnt_q} <= nom_a[k] + {1'b0, tol_n});
  end

  always_comb begin
    cls_w = SPAN_BAD;
    if      (hit[0]) cls_w = SPAN_SHORT;
    else if (hit[1]) cls_w = SPAN_LONG;
    else if (hit[2]) cls_w = SPAN_SYNC;
    else if (hit[3]) cls_w = SPAN_SYNC2;
  end

  always_comb begin
    edge_w = (lvl != prv_q);
    cnt_d  = cnt_q;
    if (edge_w)            cnt_d = CW'(1);
    else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      prv_q    <= 1'b0;
      ev_vld_q <= 1'b0;
      ev_cls_q <= SPAN_BAD;
      ev_lvl_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      prv_q    <= lvl;
      ev_vld_q <= edge_w;
      if (edge_w) begin
        ev_cls_q <= cls_w;
        ev_lvl_q <= prv_q;
      end
    end
  end

  assign ev_vld  = ev_vld_q;
  assign ev_cls  = ev_cls_q;
  assign ev_lvl  = ev_lvl_q;
  assign overdue = ({1'b0, cnt_q} > nom_a[1] + {1'b0, tol_n});

  // R3
  win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/mdec_fsm.sv
module mdec_fsm import mdec_pkg::*; #(
  parameter int WORD_BITS = 17
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ev_vld,
  input  span_e ev_cls,
  input  logic  ev_lvl,
  input  logic  overdue,
  output logic  dclk,
  output logic  sdo,
  output logic  sync_cmd,
  output logic  code_ok
);
  localparam int BCW = $clog2(WORD_BITS + 1);

  dec_st_e        st_q, st_d;
  logic           mid_q, mid_d;
  logic [BCW-1:0] bcnt_q, bcnt_d, nxt_cnt;
  logic           sl_q, sl_d;
  logic           ok_q, ok_d;
  logic           cmd_q, cmd_d;
  logic           sdo_q, sdo_d;
  logic           stb_q, stb_d;
  logic           dclk_q;
  logic           emit, err;

  always_comb begin
    st_d   = st_q;
    mid_d  = mid_q;
    bcnt_d = bcnt_q;
    sl_d   = sl_q;
    ok_d   = ok_q;
    cmd_d  = cmd_q;
    sdo_d  = sdo_q;
    stb_d  = 1'b0;
    emit   = 1'b0;
    err    = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (ev_vld && ev_cls == SPAN_SYNC) begin
          st_d = ST_SYNC2;
          sl_d = ev_lvl;
        end
      end
      ST_SYNC2: begin
        if (ev_vld) begin
          if (ev_cls == SPAN_SYNC || ev_cls == SPAN_SYNC2) begin
            st_d   = ST_DATA;
            ok_d   = 1'b1;
            cmd_d  = sl_q;
            bcnt_d = '0;
            mid_d  = (ev_cls == SPAN_SYNC2);
            emit   = (ev_cls == SPAN_SYNC2);
          end else begin
            st_d = ST_HUNT;
          end
        end
      end
      ST_DATA: begin
        if (ev_vld) begin
          if (ev_cls == SPAN_SHORT) begin
            mid_d = !mid_q;
            emit  = !mid_q;
          end else if (ev_cls == SPAN_LONG && mid_q) begin
            emit = 1'b1;
          end else begin
            err = 1'b1;
          end
        end else if (overdue) begin
          err = 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase

    nxt_cnt = ((st_q == ST_DATA) ? bcnt_q : '0) + BCW'(1);
    if (emit) begin
      sdo_d  = ev_lvl;
      stb_d  = 1'b1;
      bcnt_d = nxt_cnt;
      if (nxt_cnt == BCW'(WORD_BITS)) st_d = ST_HUNT;
    end
    if (err) begin
      ok_d = 1'b0;
      st_d = ST_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      mid_q  <= 1'b0;
      bcnt_q <= '0;
      sl_q   <= 1'b0;
      ok_q   <= 1'b0;
      cmd_q  <= 1'b0;
      sdo_q  <= 1'b0;
      stb_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mid_q  <= mid_d;
      bcnt_q <= bcnt_d;
      sl_q   <= sl_d;
      ok_q   <= ok_d;
      cmd_q  <= cmd_d;
      sdo_q  <= sdo_d;
      stb_q  <= stb_d;
      dclk_q <= stb_q;
    end
  end

  assign dclk     = dclk_q;
  assign sdo      = sdo_q;
  assign sync_cmd = cmd_q;
  assign code_ok  = ok_q;

  // R5
  dclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_q |=> !dclk_q);
  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_q |-> $stable(sdo_q));
  // R4
  ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(st_q == ST_SYNC2));
  // R6
  ok_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok_q) |-> $past(st_q == ST_DATA));
  // R6
  dclk_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_q |-> ok_q);
  // R7
  bcnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BCW'(WORD_BITS));
endmodule

// File: rtl/manch_decoder.sv
module manch_decoder import mdec_pkg::*; #(
  parameter int BP_LO       = 16,
  parameter int BP_HI       = 32,
  parameter int TOL_LO      = 2,
  parameter int TOL_HI      = 6,
  parameter int WORD_BITS   = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uni_sel,
  input  logic rate_hi,
  input  logic uni_in,
  input  logic pos_in,
  input  logic neg_in,
  output logic dclk,
  output logic sdo,
  output logic sync_cmd,
  output logic code_ok
);
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       lvl;
  logic       ev_vld, ev_lvl, overdue;
  span_e      ev_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  mdec_line_in #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n_s), .uni_sel(uni_sel), .uni_in(uni_in),
    .pos_in(pos_in), .neg_in(neg_in), .lvl_o(lvl)
  );

  mdec_span #(.BP_LO(BP_LO), .BP_HI(BP_HI), .TOL_LO(TOL_LO), .TOL_HI(TOL_HI)) u_span (
    .clk(clk), .rst_n(rst_n_s), .rate_hi(rate_hi), .lvl(lvl),
    .ev_vld(ev_vld), .ev_cls(ev_cls), .ev_lvl(ev_lvl), .overdue(overdue)
  );

  mdec_fsm #(.WORD_BITS(WORD_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .ev_vld(ev_vld), .ev_cls(ev_cls),
    .ev_lvl(ev_lvl), .overdue(overdue), .dclk(dclk), .sdo(sdo),
    .sync_cmd(sync_cmd), .code_ok(code_ok)
  );
endmodule

// File: tb/manch_decoder_test.sv
`timescale 1ns/1ps
module manch_decoder_test;
  localparam int WB = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uni_sel = 1'b1;
  logic rate_hi = 1'b0;
  logic uni_in = 1'b0;
  logic pos_in = 1'b0;
  logic neg_in = 1'b0;
  logic dclk, sdo, sync_cmd, code_ok;

  int  checks = 0;
  int  fails = 0;
  int  pulses = 0;
  bit  exp_q[$];
  bit  exp_b;
  logic cur_lvl = 1'b0;
  bit  ovl = 1'b0;
  bit  done = 1'b0;

  manch_decoder uut (
    .clk(clk), .rst_n(rst_n), .uni_sel(uni_sel), .rate_hi(rate_hi),
    .uni_in(uni_in), .pos_in(pos_in), .neg_in(neg_in),
    .dclk(dclk), .sdo(sdo), .sync_cmd(sync_cmd), .code_ok(code_ok)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected bit per strobe
  always @(negedge clk) begin
    if (rst_n && dclk) begin
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5: strobe with sdo=%0b, expected no strobe", sdo);
      end else begin
        exp_b = exp_q.pop_front();
        if (sdo !== exp_b) begin
          fails++;
          $display("FAIL R5: sdo actual %0b expected %0b", sdo, exp_b);
        end
      end
    end
  end

  task automatic put_lvl(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      uni_in = uni_sel ? v : !v;
      if (uni_sel) begin
        pos_in = !v;
        neg_in = v;
      end else if (ovl && i == 0 && v != cur_lvl) begin
        pos_in = 1'b1;
        neg_in = 1'b1;
      end else begin
        pos_in = v;
        neg_in = !v;
      end
    end
    cur_lvl = v;
  endtask

  function automatic int half();
    return rate_hi ? 16 : 8;
  endfunction

  task automatic sync_pat(input logic first, input int adj);
    put_lvl(!first, 80);
    put_lvl(first, 3 * half() + adj);
    put_lvl(!first, 3 * half());
  endtask

  task automatic send_word(input logic cmd, input logic [WB-1:0] d, input int adj, input bit expect_bits);
    sync_pat(cmd, adj);
    for (int i = WB - 1; i >= 0; i--) begin
      if (expect_bits) exp_q.push_back(d[i]);
      put_lvl(d[i], half());
      put_lvl(!d[i], half());
    end
    put_lvl(!d[0], 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
    end
  end

  initial begin
    int p0;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk("R1 dclk in reset", dclk, 0);
    chk("R1 sdo in reset", sdo, 0);
    chk("R1 code_ok in reset", code_ok, 0);
    chk("R1 sync_cmd in reset", sync_cmd, 0);
    rst_n = 1'b1;

    // R5 R4 unipolar 16x command word, no merge
    send_word(1'b1, 17'h1A5C3, 0, 1);
    chk("R5 all bits of word 1 seen", exp_q.size(), 0);
    chk("R4 code_ok after command sync", code_ok, 1);
    chk("R4 sync_cmd after command sync", sync_cmd, 1);

    // R4 data sync with merged 2.0 span
    send_word(1'b0, 17'h1F00F, 0, 1);
    chk("R5 all bits of word 2 seen", exp_q.size(), 0);
    chk("R4 sync_cmd after data sync", sync_cmd, 0);
    chk("R4 code_ok after data sync", code_ok, 1);

    // R2 R3 bipolar 32x command word with merge
    uni_sel = 1'b0; rate_hi = 1'b1;
    send_word(1'b1, 17'h0B3E5, 0, 1);
    chk("R3 all bits at 32x seen", exp_q.size(), 0);
    chk("R2 sync_cmd bipolar", sync_cmd, 1);

    // R2 bipolar with one-cycle overlaps at 16x
    rate_hi = 1'b0; ovl = 1'b1;
    send_word(1'b0, 17'h05555, 0, 1);
    chk("R2 overlap word decoded", exp_q.size(), 0);
    chk("R2 overlap not an error", code_ok, 1);
    ovl = 1'b0;

    // R2 unipolar ignores the pair (pair driven inverted as noise)
    uni_sel = 1'b1;
    send_word(1'b1, 17'h13579, 0, 1);
    chk("R2 pair ignored in unipolar mode", exp_q.size(), 0);

    // R3 tolerance edges at 16x
    send_word(1'b1, 17'h1ACE1, 2, 1);
    chk("R3 sync half +2 accepted", exp_q.size(), 0);
    p0 = pulses;
    send_word(1'b1, 17'h1ACE1, 3, 0);
    chk("R3 sync half +3 rejected", pulses - p0, 0);
    // R3 tolerance edges at 32x
    rate_hi = 1'b1;
    send_word(1'b0, 17'h0F0F0, -6, 1);
    chk("R3 sync half -6 accepted", exp_q.size(), 0);
    p0 = pulses;
    send_word(1'b0, 17'h0F0F0, -7, 0);
    chk("R3 sync half -7 rejected", pulses - p0, 0);
    rate_hi = 1'b0;

    // R6 out-of-window span right after sync
    p0 = pulses;
    sync_pat(1'b1, 0);
    put_lvl(1'b1, 12);
    put_lvl(1'b0, 8); put_lvl(1'b1, 8); put_lvl(1'b0, 16); put_lvl(1'b1, 20);
    chk("R6 bad span clears code_ok", code_ok, 0);
    chk("R6 no strobe after bad span", pulses - p0, 0);

    // R6 missing mid-bit transition
    send_word(1'b1, 17'h1A5C3, 0, 1);
    chk("R6 flag restored by new sync", code_ok, 1);
    p0 = pulses;
    sync_pat(1'b1, 0);
    put_lvl(1'b1, 16);
    put_lvl(1'b0, 8); put_lvl(1'b1, 8); put_lvl(1'b0, 20);
    chk("R6 missing mid-bit clears code_ok", code_ok, 0);
    chk("R6 no strobe after missing mid-bit", pulses - p0, 0);

    // R6 no transition for too long: bits 1 then 0 decoded first
    sync_pat(1'b1, 0);
    exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    put_lvl(1'b1, 8); put_lvl(1'b0, 16); put_lvl(1'b1, 60);
    chk("R6 bits before stall decoded", exp_q.size(), 0);
    chk("R6 stall clears code_ok", code_ok, 0);

    // R7 transitions after a completed word
    send_word(1'b0, 17'h0AAAA, 0, 1);
    p0 = pulses;
    put_lvl(1'b1, 8); put_lvl(1'b0, 8); put_lvl(1'b1, 16); put_lvl(1'b0, 16);
    put_lvl(1'b1, 8); put_lvl(1'b0, 30);
    chk("R7 no strobe after word end", pulses - p0, 0);
    chk("R7 code_ok kept", code_ok, 1);
    chk("R7 sync_cmd kept", sync_cmd, 0);

    // R1 reset in the middle of a word
    sync_pat(1'b1, 0);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(1'b1);
      put_lvl(1'b1, 8); put_lvl(1'b0, 8);
    end
    chk("R1 bits before reset", exp_q.size(), 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 dclk cleared at once", dclk, 0);
    chk("R1 code_ok cleared at once", code_ok, 0);
    chk("R1 sync_cmd cleared at once", sync_cmd, 0);
    chk("R1 sdo cleared at once", sdo, 0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      put_lvl(1'b0, 8); put_lvl(1'b1, 8);
    end
    put_lvl(1'b1, 20);
    chk("R1 no strobe before new sync", pulses - p0, 0);
    send_word(1'b1, 17'h1C3A5, 0, 1);
    chk("R1 decoding resumes after sync", exp_q.size(), 0);
    chk("R1 code_ok after resume", code_ok, 1);

    done = 1'b1;
    summary();
  end
endmodule